// File: doc/BRIEF.md
# Ethernet Multicast Hash Filter

This block decides whether a received frame aimed at a group address should be kept. It holds a 512-bit acceptance table, organised as 32 words of 16 bits. Each bit stands for one hash bucket of the group address space. Software adds or removes an address through an update port. The block hashes that address and sets or clears the matching bit. The receive path presents each destination address on a lookup port. One cycle later it gets a valid flag and an accept decision.

The hash is the reflected Ethernet CRC-32 of the six address bytes. It is computed in a single combinational step on both ports. A synchronous clear brings the table back to its base state in one cycle. In that base state only the broadcast bucket is set. A read port exposes any table word, so the contents can be inspected.

Two mode inputs widen acceptance without touching the stored bits:
- All-multicast makes every group address pass, and makes the table read as all ones.
- Promiscuous makes every frame pass.

Top module: `mcast_hash_filter`

## Requirements
- R1: The bucket index of an address is the low 9 bits of a 32-bit CRC register. The register starts at all ones. The 48 address bits are shifted in one per step. Byte `addr[47:40]` is shifted first and `addr[7:0]` last, and each byte is shifted least significant bit first. At each step the feedback is register bit 0 XOR the data bit. The register shifts right, and the constant 0xEDB88320 is XORed in when the feedback is 1. No final inversion is applied. Index bits [8:4] select the word and bits [3:0] select the bit within that word.
- R2: An accepted add update sets the bucket bit of `upd_addr_i` at the clock edge and leaves every other table bit unchanged.
- R3: An accepted remove update clears the bucket bit of `upd_addr_i` and leaves every other table bit unchanged.
- R4: `upd_done_o` is high for exactly the one cycle after an accepted update. An update is accepted when `upd_valid_i` is high and `clear_i` is low.
- R5: After reset, and after any cycle with `clear_i` high, the table holds only the bucket bit of the broadcast address FF:FF:FF:FF:FF:FF. An update presented in the same cycle as a clear is dropped: the table is not written and `upd_done_o` stays low.
- R6: `rd_word_o` shows table word `rd_sel_i` combinationally. While `allmulti_i` is high it reads 0xFFFF instead. The stored contents are kept and reappear when `allmulti_i` falls.
- R7: In the cycle after a lookup is presented (`lk_valid_i` high), `lk_valid_o` is high. For a group address (bit 40 of `lk_addr_i` set) with both modes low, `lk_accept_o` equals the table bit at the address's bucket. The bit is read from the table as it stood before that edge, so an update in the same cycle is not seen. `lk_valid_o` is low in every other cycle.
- R8: A lookup of an individual address (bit 40 of `lk_addr_i` clear) returns accept = 1, whatever the table holds.
- R9: With `allmulti_i` high, every group-address lookup returns accept = 1.
- R10: With `promisc_i` high, every lookup returns accept = 1.
- R11: During and right after reset, `upd_done_o`, `lk_valid_o` and `lk_accept_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear to the broadcast-only table |
| promisc_i | input | 1 | Accept every frame |
| allmulti_i | input | 1 | Accept every group address; table reads as ones |
| upd_valid_i | input | 1 | Update request |
| upd_add_i | input | 1 | 1 = add (set bit), 0 = remove (clear bit) |
| upd_addr_i | input | 48 | Address to hash for the update; first byte in [47:40] |
| upd_done_o | output | 1 | One-cycle pulse after an accepted update |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | 48 | Destination address to classify; group bit is bit 40 |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_accept_o | output | 1 | Lookup result: 1 = accept |
| rd_sel_i | input | 5 | Table word to read |
| rd_word_o | output | 16 | Selected table word |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a clear and an update. The bench drives both at once and expects no done pulse, with the table left at its broadcast-only base state. The second pair is a lookup and an update of the same address. The bench picks a group address whose bucket is empty and adds it while looking it up in the same cycle. The returned decision must be reject. A repeat lookup one cycle later must accept. Around these cases, a sweep of several hundred updates and lookups compares every table word and every decision against a reference table built in the bench.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned ADDR_W = 48;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned N_WORDS = 32;
  localparam int unsigned IDX_W = $clog2(WORD_W * N_WORDS);
  localparam int unsigned BIT_W = $clog2(WORD_W);
  localparam int unsigned SEL_W = IDX_W - BIT_W;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam int unsigned GROUP_BIT = ADDR_W - 8;

  // reflected CRC, first byte in the top octet, each byte LSB first
  function automatic logic [31:0] mhf_crc(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int n = 0; n < int'(ADDR_W); n++) begin
      fb = c[0] ^ a[ADDR_W - 8 - 8 * (n / 8) + (n % 8)];
      c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY : 32'h0);
    end
    return c;
  endfunction

  localparam logic [31:0] BC_CRC = mhf_crc({ADDR_W{1'b1}});
  localparam logic [IDX_W-1:0] BC_IDX = BC_CRC[IDX_W-1:0];
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
  import mhf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [BIT_W-1:0]  bit_o
);
  logic [31:0] crc;
  logic [IDX_W-1:0] idx;

  assign crc   = mhf_crc(addr_i);
  assign idx   = crc[IDX_W-1:0];
  assign bit_o = idx[BIT_W-1:0];
  assign sel_o = idx[IDX_W-1:BIT_W];
endmodule

// File: rtl/mhf_table.sv
module mhf_table
  import mhf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic              wr_set_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BIT_W-1:0]  wr_bit_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic [SEL_W-1:0]  lk_sel_i,
  input  logic [BIT_W-1:0]  lk_bit_i,
  output logic              lk_bit_o
);
  localparam logic [SEL_W-1:0] BC_SEL = BC_IDX[IDX_W-1:BIT_W];
  localparam logic [BIT_W-1:0] BC_BIT = BC_IDX[BIT_W-1:0];

  logic [N_WORDS-1:0][WORD_W-1:0] words;

  for (genvar w = 0; w < int'(N_WORDS); w++) begin : g_word
    localparam logic [WORD_W-1:0] BASE =
      (SEL_W'(w) == BC_SEL) ? (WORD_W'(1) << BC_BIT) : '0;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                word_q <= BASE;
      else if (clr_i)                             word_q <= BASE;
      else if (wr_en_i && wr_sel_i == SEL_W'(w))  word_q[wr_bit_i] <= wr_set_i;
    end

    assign words[w] = word_q;
  end

  assign rd_word_o = words[rd_sel_i];
  assign lk_bit_o  = words[lk_sel_i][lk_bit_i];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
  import mhf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              promisc_i,
  input  logic              allmulti_i,
  input  logic              upd_valid_i,
  input  logic              upd_add_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  output logic              upd_done_o,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_valid_o,
  output logic              lk_accept_o,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [SEL_W-1:0]  upd_sel, lk_sel;
  logic [BIT_W-1:0]  upd_bit, lk_bit;
  logic [WORD_W-1:0] raw_word;
  logic              lk_hit, upd_go, lk_group, accept_d;

  mhf_hash u_upd_hash (.addr_i(upd_addr_i), .sel_o(upd_sel), .bit_o(upd_bit));
  mhf_hash u_lk_hash  (.addr_i(lk_addr_i),  .sel_o(lk_sel),  .bit_o(lk_bit));

  assign upd_go = upd_valid_i && !clear_i;

  mhf_table u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clear_i),
    .wr_en_i   (upd_go),
    .wr_set_i  (upd_add_i),
    .wr_sel_i  (upd_sel),
    .wr_bit_i  (upd_bit),
    .rd_sel_i  (rd_sel_i),
    .rd_word_o (raw_word),
    .lk_sel_i  (lk_sel),
    .lk_bit_i  (lk_bit),
    .lk_bit_o  (lk_hit)
  );

  assign rd_word_o = allmulti_i ? '1 : raw_word;
  assign lk_group  = lk_addr_i[GROUP_BIT];
  assign accept_d  = promisc_i || !lk_group || allmulti_i || lk_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_done_o  <= 1'b0;
      lk_valid_o  <= 1'b0;
      lk_accept_o <= 1'b0;
    end else begin
      upd_done_o  <= upd_go;
      lk_valid_o  <= lk_valid_i;
      lk_accept_o <= lk_valid_i && accept_d;
    end
  end
endmodule

// File: rtl/mcast_hash_filter_chk.sv
module mcast_hash_filter_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clear_i,
  input logic        promisc_i,
  input logic        allmulti_i,
  input logic        upd_valid_i,
  input logic        upd_done_o,
  input logic        lk_valid_i,
  input logic        lk_grp_i,
  input logic        lk_valid_o,
  input logic        lk_accept_o,
  input logic [15:0] rd_word_o
);
  assert_done_after_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !clear_i) |=> upd_done_o);
  assert_no_spurious_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> !upd_done_o);
  assert_clear_drops_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !upd_done_o);
  assert_lookup_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o);
  assert_lookup_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !lk_valid_o);
  assert_unicast_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_grp_i) |=> lk_accept_o);
  assert_allmulti_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && allmulti_i) |=> lk_accept_o);
  assert_promisc_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && promisc_i) |=> lk_accept_o);
  assert_allmulti_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allmulti_i |-> rd_word_o == 16'hFFFF);
endmodule

bind mcast_hash_filter mcast_hash_filter_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clear_i     (clear_i),
  .promisc_i   (promisc_i),
  .allmulti_i  (allmulti_i),
  .upd_valid_i (upd_valid_i),
  .upd_done_o  (upd_done_o),
  .lk_valid_i  (lk_valid_i),
  .lk_grp_i    (lk_addr_i[40]),
  .lk_valid_o  (lk_valid_o),
  .lk_accept_o (lk_accept_o),
  .rd_word_o   (rd_word_o)
);

// File: tb/mcast_hash_filter_test.sv
module mcast_hash_filter_test;
  timeunit 1ns;
  timeprecision 10ps;

  localparam real CLK_PERIOD = 10.0;
  localparam int  WATCHDOG_CYC = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0, promisc_i = 1'b0, allmulti_i = 1'b0;
  logic        upd_valid_i = 1'b0, upd_add_i = 1'b0;
  logic [47:0] upd_addr_i = '0;
  logic        upd_done_o;
  logic        lk_valid_i = 1'b0;
  logic [47:0] lk_addr_i = '0;
  logic        lk_valid_o, lk_accept_o;
  logic [4:0]  rd_sel_i = '0;
  logic [15:0] rd_word_o;

  int n_vec = 0, n_bad = 0;
  logic [15:0] model [32];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  mcast_hash_filter uut (.*);

  // reference hash: byte-wise, first byte on top, LSB of each byte first
  function automatic int bucket(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int b = 5; b >= 0; b--) begin
      logic [7:0] by = a[b*8 +: 8];
      for (int k = 0; k < 8; k++) begin
        logic f = r[0] ^ by[0];
        r  = r >> 1;
        by = by >> 1;
        if (f) r = r ^ 32'hEDB88320;
      end
    end
    return int'(r & 32'h1FF);
  endfunction

  function automatic logic [47:0] gen_addr(input int i, input bit grp);
    logic [47:0] a;
    a = {32'(i) * 32'h9E3779B1, 16'(i * 40503 + 7)};
    a[40] = grp;
    return a;
  endfunction

  function automatic bit model_bit(input logic [47:0] a);
    int x = bucket(a);
    return model[x / 16][x % 16];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_base();
    int bi = bucket(48'hFFFF_FFFF_FFFF);
    for (int w = 0; w < 32; w++) model[w] = '0;
    model[bi / 16][bi % 16] = 1'b1;
  endtask

  task automatic check_table(input string req);
    for (int w = 0; w < 32; w++) begin
      rd_sel_i = 5'(w);
      #0.05;
      chk(req, {16'h0, rd_word_o}, {16'h0, allmulti_i ? 16'hFFFF : model[w]});
    end
  endtask

  task automatic do_update(input bit add, input logic [47:0] a, input string req);
    int x = bucket(a);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_add_i = add; upd_addr_i = a;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    model[x / 16][x % 16] = add;
    chk("R4 done", {31'h0, upd_done_o}, 32'h1);
    @(negedge clk_i);
    chk("R4 single pulse", {31'h0, upd_done_o}, 32'h0);
    check_table(req);
  endtask

  task automatic do_lookup(input logic [47:0] a, input bit exp, input string req);
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_addr_i = a;
    @(negedge clk_i);
    lk_valid_i = 1'b0;
    chk("R7 valid", {31'h0, lk_valid_o}, 32'h1);
    chk(req, {31'h0, lk_accept_o}, {31'h0, exp});
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYC) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [47:0] fresh;
    model_base();
    #(CLK_PERIOD * 2.3);
    // R11 outputs quiet in reset
    chk("R11 done in reset", {31'h0, upd_done_o}, 32'h0);
    chk("R11 lk_valid in reset", {31'h0, lk_valid_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 lk_accept after reset", {31'h0, lk_accept_o}, 32'h0);
    chk("R11 done after reset", {31'h0, upd_done_o}, 32'h0);
    check_table("R5 reset base table");
    chk("R7 idle", {31'h0, lk_valid_o}, 32'h0);

    // R1 R2 sweep adds
    for (int i = 0; i < 120; i++) do_update(1'b1, gen_addr(i, 1'b1), "R2 R1 add");
    // R3 removes
    for (int i = 0; i < 120; i += 2) do_update(1'b0, gen_addr(i, 1'b1), "R3 R1 remove");

    // R7 group lookups against model
    for (int i = 0; i < 200; i++) do_lookup(gen_addr(i, 1'b1), model_bit(gen_addr(i, 1'b1)), "R7 R1 group lookup");
    // R8 unicast
    for (int i = 0; i < 40; i++) do_lookup(gen_addr(i + 500, 1'b0), 1'b1, "R8 unicast pass");

    // R9 R6 all-multicast
    allmulti_i = 1'b1;
    check_table("R6 allmulti read");
    for (int i = 300; i < 340; i++) do_lookup(gen_addr(i, 1'b1), 1'b1, "R9 allmulti accept");
    allmulti_i = 1'b0;
    check_table("R6 content kept after allmulti");

    // R10 promiscuous
    promisc_i = 1'b1;
    for (int i = 300; i < 340; i++) do_lookup(gen_addr(i, 1'b1), 1'b1, "R10 promisc group");
    for (int i = 600; i < 610; i++) do_lookup(gen_addr(i, 1'b0), 1'b1, "R10 promisc unicast");
    promisc_i = 1'b0;

    // R7 lookup and update of the same empty bucket in one cycle
    fresh = '0;
    for (int i = 1000; i < 1400; i++)
      if (fresh == '0 && !model_bit(gen_addr(i, 1'b1))) fresh = gen_addr(i, 1'b1);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_add_i = 1'b1; upd_addr_i = fresh;
    lk_valid_i = 1'b1; lk_addr_i = fresh;
    @(negedge clk_i);
    upd_valid_i = 1'b0; lk_valid_i = 1'b0;
    chk("R7 same-cycle lookup sees old table", {31'h0, lk_accept_o}, 32'h0);
    chk("R4 done with lookup", {31'h0, upd_done_o}, 32'h1);
    begin
      int x = bucket(fresh);
      model[x / 16][x % 16] = 1'b1;
    end
    do_lookup(fresh, 1'b1, "R7 R2 lookup after add");

    // R5 clear plus concurrent update
    @(negedge clk_i);
    clear_i = 1'b1; upd_valid_i = 1'b1; upd_add_i = 1'b1; upd_addr_i = gen_addr(7, 1'b1);
    @(negedge clk_i);
    clear_i = 1'b0; upd_valid_i = 1'b0;
    chk("R5 clear drops update done", {31'h0, upd_done_o}, 32'h0);
    model_base();
    check_table("R5 clear base table");
    do_lookup(48'hFFFF_FFFF_FFFF, 1'b1, "R5 broadcast after clear");
    do_lookup(gen_addr(7, 1'b1), model_bit(gen_addr(7, 1'b1)), "R5 dropped update absent");

    // R3 remove of absent bucket changes nothing
    do_update(1'b0, gen_addr(9, 1'b1), "R3 remove absent");
    do_update(1'b1, gen_addr(9, 1'b1), "R2 add after clear");
    do_update(1'b1, gen_addr(9, 1'b1), "R2 add twice");

    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule